// File: doc/BRIEF.md
# Audio Sample-Rate Clock Generator

This block derives the serial bit clock and two frame (left/right) clocks, one for the record path and one for the playback path, from a single master clock. It uses only counters, with no PLL. A 12.288 MHz master clock, or twice that with the internal halving switched on, gives the standard audio rates from 8 kHz to 96 kHz. A four-bit rate code picks the record and playback divide ratios together, so the two paths can run at different rates as long as one rate is a whole multiple of the other.

In master mode the block drives all three clocks and raises their output enables. In slave mode every output enable is low, so the pins are left to an external clock source. Each frame clock is gated by the converter path it serves. A sharing option keeps both frame clocks alive while either path is enabled. The bit clock runs at 64 times the faster of the two frame rates, and each frame clock moves only on a falling bit-clock edge.

A new rate code is taken on only at a frame boundary common to both paths, so no short pulse appears on any clock.

Top module: `acg_clkgen`

## Requirements
- R1: While reset is low (sampled on a rising master-clock edge), the bit clock, both frame clocks and all three output enables read 0. The first master tick after reset release starts the first low half of a fresh bit-clock period and a fresh frame.
- R2: The bit clock is low for H master ticks and then high for H master ticks. H is the value of the active rate code.
- R3: Rate codes, given as (H, record frame length in bit clocks, playback frame length in bit clocks): 0:(2,64,64) 1:(2,384,64) 2:(2,64,384) 3:(12,64,64) 4:(3,64,64) 5:(1,64,64) 6:(6,64,64) 7:(4,64,64) 8:(8,64,64) 9:(2,64,128) 10:(2,128,64) 11:(2,64,192). Codes 12 to 15 behave as code 0.
- R4: Each frame clock is low for the first half of its frame and high for the second half, giving a 50% duty cycle.
- R5: A frame clock that is enabled changes value only in the master cycle in which the bit clock falls.
- R6: When mclk_halve is 1, a master tick happens on every second master-clock edge, beginning with the second edge. When it is 0, every edge is a tick.
- R7: A change on rate_sel takes effect only at the tick where both frame clocks begin a new frame together. The value of rate_sel at that tick is the one loaded.
- R8: One master-clock cycle after master_en is sampled 1, bclk_oe is 1. One cycle after master_en is sampled 0, all three output enables are 0, and so are all three clock outputs.
- R9: With lrc_share at 0, each frame clock's output enable follows master_en AND that path's converter enable, one cycle later. When its enable is 0, that clock output reads 0.
- R10: With lrc_share at 1, both frame-clock output enables follow master_en AND (adc_en OR dac_en), one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_halve | input | 1 | Halve the master clock before all division |
| rate_sel | input | 4 | Rate code choosing both frame ratios |
| master_en | input | 1 | 1 = drive the clocks, 0 = slave (no drive) |
| adc_en | input | 1 | Record converter enabled |
| dac_en | input | 1 | Playback converter enabled |
| lrc_share | input | 1 | Gate both frame clocks only when both converters are off |
| bclk_o | output | 1 | Serial bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| adc_lrc_o | output | 1 | Record frame clock |
| adc_lrc_oe | output | 1 | Record frame clock output enable |
| dac_lrc_o | output | 1 | Playback frame clock |
| dac_lrc_oe | output | 1 | Playback frame clock output enable |

## Verification
The hardest case to reach is a rate change that lands in the middle of a long mixed-rate superframe. There the slow frame clock has many fast frames still to run, and the new code must wait for the one tick where both paths wrap together. The stimulus changes rate_sel at many offsets, including in the middle of 384-bit-clock frames and across changes of the bit-clock divisor. A tick-count reference model predicts the exact cycle at which the switch takes effect. Gating and the halved tick are combined with these sequences so that the enables change while frames are partly done.

// File: rtl/acg_pkg.sv
// Shared widths, configuration type and rate-code decode for the clock generator.
// Assumes every rate pair uses ratios that are whole multiples of each other.
package acg_pkg;
    localparam int FRAME_BCLKS = 64;   // bit clocks per frame at the faster rate
    localparam int RSEL_W      = 4;
    localparam int HALF_W      = 5;    // holds the half bit-clock period in ticks
    localparam int POS_W       = 10;   // holds the longest frame in bit clocks

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [POS_W-1:0]  rec_len;
        logic [POS_W-1:0]  play_len;
    } rate_cfg_t;

    // Build a configuration from two ratios given in units of 128 master ticks.
    function automatic rate_cfg_t make_cfg(input int rec_m, input int play_m);
        rate_cfg_t c;
        int mn;
        int rl;
        int pl;
        mn = (rec_m < play_m) ? rec_m : play_m;
        rl = FRAME_BCLKS * rec_m / mn;
        pl = FRAME_BCLKS * play_m / mn;
        c.half     = mn[HALF_W-1:0];
        c.rec_len  = rl[POS_W-1:0];
        c.play_len = pl[POS_W-1:0];
        return c;
    endfunction

    // Map a rate code to its record/playback ratio pair.
    function automatic rate_cfg_t decode_rate(input logic [RSEL_W-1:0] code);
        case (code)
            4'd1:    return make_cfg(12, 2);
            4'd2:    return make_cfg(2, 12);
            4'd3:    return make_cfg(12, 12);
            4'd4:    return make_cfg(3, 3);
            4'd5:    return make_cfg(1, 1);
            4'd6:    return make_cfg(6, 6);
            4'd7:    return make_cfg(4, 4);
            4'd8:    return make_cfg(8, 8);
            4'd9:    return make_cfg(2, 4);
            4'd10:   return make_cfg(4, 2);
            4'd11:   return make_cfg(2, 6);
            default: return make_cfg(2, 2);
        endcase
    endfunction
endpackage

// File: rtl/acg_tick_gen.sv
// Produces the master tick enable: every edge, or every second edge when halving.
// Assumes the halve select is quasi-static.
module acg_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic halve,
    output logic tick
);
    logic phase_q;

    // Alternate phase while halving so that every second edge is a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= halve ? ~phase_q : 1'b0;
    end

    assign tick = ~halve | phase_q;
endmodule

// File: rtl/acg_bclk_gen.sv
// Bit-clock divider: toggles every 'half' ticks and flags the falling edge.
// Assumes 'half' is at least 1 and changes only in a falling-edge cycle.
module acg_bclk_gen #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [HALF_W-1:0] half,
    output logic              bclk,
    output logic              fall_evt
);
    logic [HALF_W-1:0] cnt_q;
    logic              last;

    assign last     = (cnt_q == half - HALF_W'(1));
    assign fall_evt = tick & last & bclk;

    // Count ticks within a half period and flip the bit clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
        end else if (tick) begin
            if (last) begin
                cnt_q <= '0;
                bclk  <= ~bclk;
            end else begin
                cnt_q <= cnt_q + HALF_W'(1);
            end
        end
    end
endmodule

// File: rtl/acg_frame_div.sv
// Frame-clock divider stepped on each falling bit clock; low half then high half.
// Assumes 'len' is even and changes only while the position wraps.
module acg_frame_div #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [POS_W-1:0] len,
    output logic             lrc,
    output logic             at_end
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nx;

    assign at_end = (pos_q == len - POS_W'(1));
    assign pos_nx = at_end ? '0 : pos_q + POS_W'(1);

    // Advance the frame position and derive the registered frame level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            lrc   <= 1'b0;
        end else if (step) begin
            pos_q <= pos_nx;
            lrc   <= (pos_nx >= (len >> 1));
        end
    end
endmodule

// File: rtl/acg_clkgen.sv
// Top of the audio sample-rate clock generator: tick, bit clock, two frame
// dividers, rate loading at common frame boundaries, and output gating.
// Assumes a single master clock domain; outputs are driven only in master mode.
module acg_clkgen
    import acg_pkg::*;
(
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              mclk_halve,
    input  logic [RSEL_W-1:0] rate_sel,
    input  logic              master_en,
    input  logic              adc_en,
    input  logic              dac_en,
    input  logic              lrc_share,
    output logic              bclk_o,
    output logic              bclk_oe,
    output logic              adc_lrc_o,
    output logic              adc_lrc_oe,
    output logic              dac_lrc_o,
    output logic              dac_lrc_oe
);
    localparam int NPATH = 2;   // 0 = record, 1 = playback

    logic             tick;
    logic             bclk_int;
    logic             fall_evt;
    rate_cfg_t        cfg_q;
    logic [POS_W-1:0] len_v [NPATH];
    logic [NPATH-1:0] lrc_v;
    logic [NPATH-1:0] end_v;
    logic             load;
    logic             master_q;
    logic [NPATH-1:0] gate_q;
    logic [NPATH-1:0] gate_nx;

    acg_tick_gen u_tick (
        .clk   (mclk),
        .rst_n (rst_n),
        .halve (mclk_halve),
        .tick  (tick)
    );

    acg_bclk_gen #(.HALF_W(HALF_W)) u_bclk (
        .clk      (mclk),
        .rst_n    (rst_n),
        .tick     (tick),
        .half     (cfg_q.half),
        .bclk     (bclk_int),
        .fall_evt (fall_evt)
    );

    assign len_v[0] = cfg_q.rec_len;
    assign len_v[1] = cfg_q.play_len;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        acg_frame_div #(.POS_W(POS_W)) u_div (
            .clk    (mclk),
            .rst_n  (rst_n),
            .step   (fall_evt),
            .len    (len_v[p]),
            .lrc    (lrc_v[p]),
            .at_end (end_v[p])
        );
    end

    assign load = fall_evt & (&end_v);

    // Hold the active rate; reload it only where both frames wrap together.
    always_ff @(posedge mclk) begin
        if (!rst_n)    cfg_q <= decode_rate(rate_sel);
        else if (load) cfg_q <= decode_rate(rate_sel);
    end

    // Per-path gate: own converter, or either converter in sharing mode.
    always_comb begin
        gate_nx[0] = master_en & (lrc_share ? (adc_en | dac_en) : adc_en);
        gate_nx[1] = master_en & (lrc_share ? (adc_en | dac_en) : dac_en);
    end

    // Register the drive decisions so enables change cleanly on a clock edge.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            gate_q   <= '0;
        end else begin
            master_q <= master_en;
            gate_q   <= gate_nx;
        end
    end

    assign bclk_oe    = master_q;
    assign bclk_o     = bclk_int & master_q;
    assign adc_lrc_oe = gate_q[0];
    assign adc_lrc_o  = lrc_v[0] & gate_q[0];
    assign dac_lrc_oe = gate_q[1];
    assign dac_lrc_o  = lrc_v[1] & gate_q[1];
endmodule

// File: rtl/acg_clkgen_chk.sv
// Assertion checker for the clock generator, bound to the top module.
// Assumes reset is held for at least one clock edge at start-up.
module acg_clkgen_chk #(
    parameter int HALF_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_en,
    input logic              adc_en,
    input logic              dac_en,
    input logic              lrc_share,
    input logic              bclk_o,
    input logic              bclk_oe,
    input logic              adc_lrc_o,
    input logic              adc_lrc_oe,
    input logic              dac_lrc_o,
    input logic              dac_lrc_oe,
    input logic              bclk_int,
    input logic [HALF_W-1:0] cfg_half
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bclk_o && !adc_lrc_o && !dac_lrc_o && !bclk_oe); // R1
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !bclk_oe && !adc_lrc_oe && !dac_lrc_oe && !bclk_o); // R8
    AST_MASTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        master_en |=> bclk_oe); // R8
    AST_ADC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !lrc_share && !adc_en |=> !adc_lrc_oe && !adc_lrc_o); // R9
    AST_DAC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !lrc_share && !dac_en |=> !dac_lrc_oe && !dac_lrc_o); // R9
    AST_SHARE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        master_en && lrc_share && (adc_en || dac_en) |=> adc_lrc_oe && dac_lrc_oe); // R10
    AST_SHARE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        lrc_share && !adc_en && !dac_en |=> !adc_lrc_oe && !dac_lrc_oe); // R10
    AST_ADC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && adc_lrc_oe && $past(adc_lrc_oe) && !$stable(adc_lrc_o)
        |-> $fell(bclk_int)); // R5
    AST_DAC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && dac_lrc_oe && $past(dac_lrc_oe) && !$stable(dac_lrc_o)
        |-> $fell(bclk_int)); // R5
    AST_RATE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(cfg_half) |-> $fell(bclk_int)); // R7
endmodule

bind acg_clkgen acg_clkgen_chk #(.HALF_W(acg_pkg::HALF_W)) u_chk (
    .clk        (mclk),
    .rst_n      (rst_n),
    .master_en  (master_en),
    .adc_en     (adc_en),
    .dac_en     (dac_en),
    .lrc_share  (lrc_share),
    .bclk_o     (bclk_o),
    .bclk_oe    (bclk_oe),
    .adc_lrc_o  (adc_lrc_o),
    .adc_lrc_oe (adc_lrc_oe),
    .dac_lrc_o  (dac_lrc_o),
    .dac_lrc_oe (dac_lrc_oe),
    .bclk_int   (bclk_int),
    .cfg_half   (cfg_q.half)
);

// File: tb/acg_clkgen_bench.sv
// Self-checking bench: a tick-count reference model compared every cycle.
module acg_clkgen_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n = 1'b0;
    logic       mclk_halve = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       master_en = 1'b1;
    logic       adc_en = 1'b1;
    logic       dac_en = 1'b1;
    logic       lrc_share = 1'b0;
    logic bclk_o, bclk_oe, adc_lrc_o, adc_lrc_oe, dac_lrc_o, dac_lrc_oe;

    acg_clkgen u_acg_clkgen (
        .mclk(clk), .rst_n(rst_n), .mclk_halve(mclk_halve), .rate_sel(rate_sel),
        .master_en(master_en), .adc_en(adc_en), .dac_en(dac_en), .lrc_share(lrc_share),
        .bclk_o(bclk_o), .bclk_oe(bclk_oe), .adc_lrc_o(adc_lrc_o), .adc_lrc_oe(adc_lrc_oe),
        .dac_lrc_o(dac_lrc_o), .dac_lrc_oe(dac_lrc_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state: ticks since the common frame start, plus the rate.
    int m_e = 0, m_h = 2, m_pr = 64, m_pp = 64;
    bit m_ph = 0, m_mq = 0, m_ag = 0, m_dg = 0;
    bit p_adc = 0, p_dac = 0, p_bclk = 0, p_aoe = 0, p_doe = 0;

    task automatic rate_tab(input int code, output int th, output int tpr, output int tpp);
        case (code)
            1:  begin th = 2;  tpr = 384; tpp = 64;  end
            2:  begin th = 2;  tpr = 64;  tpp = 384; end
            3:  begin th = 12; tpr = 64;  tpp = 64;  end
            4:  begin th = 3;  tpr = 64;  tpp = 64;  end
            5:  begin th = 1;  tpr = 64;  tpp = 64;  end
            6:  begin th = 6;  tpr = 64;  tpp = 64;  end
            7:  begin th = 4;  tpr = 64;  tpp = 64;  end
            8:  begin th = 8;  tpr = 64;  tpp = 64;  end
            9:  begin th = 2;  tpr = 64;  tpp = 128; end
            10: begin th = 2;  tpr = 128; tpp = 64;  end
            11: begin th = 2;  tpr = 64;  tpp = 192; end
            default: begin th = 2; tpr = 64; tpp = 64; end
        endcase
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One master cycle: update the model at the edge, compare at the falling edge.
    task automatic step();
        int sl;
        bit tk;
        @(posedge clk);
        if (!rst_n) begin
            m_e = 0; m_ph = 0; m_mq = 0; m_ag = 0; m_dg = 0;
            rate_tab(int'(rate_sel), m_h, m_pr, m_pp);
        end else begin
            tk = !mclk_halve || m_ph;
            m_ph = mclk_halve ? !m_ph : 1'b0;
            if (tk) begin
                sl = 2 * m_h * ((m_pr > m_pp) ? m_pr : m_pp);
                m_e++;
                if (m_e == sl) begin
                    m_e = 0;
                    rate_tab(int'(rate_sel), m_h, m_pr, m_pp);
                end
            end
            m_mq = master_en;
            m_ag = master_en && (lrc_share ? (adc_en || dac_en) : adc_en);
            m_dg = master_en && (lrc_share ? (adc_en || dac_en) : dac_en);
        end
        @(negedge clk);
        check("R2 R3 R6 R7 bclk", int'(bclk_o), int'(m_mq && ((m_e / m_h) % 2 == 1)));
        check("R3 R4 R7 adc frame", int'(adc_lrc_o),
              int'(m_ag && (((m_e / (2 * m_h)) % m_pr) >= m_pr / 2)));
        check("R3 R4 R7 dac frame", int'(dac_lrc_o),
              int'(m_dg && (((m_e / (2 * m_h)) % m_pp) >= m_pp / 2)));
        check("R8 bclk_oe", int'(bclk_oe), int'(m_mq));
        check("R9 R10 adc_oe", int'(adc_lrc_oe), int'(m_ag));
        check("R9 R10 dac_oe", int'(dac_lrc_oe), int'(m_dg));
        if (rst_n && adc_lrc_oe && p_aoe && adc_lrc_o != p_adc)
            check("R5 adc moves on bclk fall", int'(p_bclk && !bclk_o), 1);
        if (rst_n && dac_lrc_oe && p_doe && dac_lrc_o != p_dac)
            check("R5 dac moves on bclk fall", int'(p_bclk && !bclk_o), 1);
        p_adc = adc_lrc_o; p_dac = dac_lrc_o; p_bclk = bclk_o;
        p_aoe = adc_lrc_oe; p_doe = dac_lrc_oe;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Cycles between two rising edges of a chosen output (0 bclk, 1 adc, 2 dac).
    task automatic meas(input int which, output int per);
        bit cur, prv;
        int cnt;
        per = -1; cnt = -1; prv = 1'b1;
        for (int i = 0; i < 5000 && per < 0; i++) begin
            step();
            cur = (which == 0) ? bclk_o : (which == 1) ? adc_lrc_o : dac_lrc_o;
            if (cnt >= 0) cnt++;
            if (cur && !prv) begin
                if (cnt > 0) per = cnt;
                else cnt = 0;
            end
            prv = cur;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run(3);
        check("R1 bclk in reset", int'(bclk_o), 0);
        check("R1 adc in reset", int'(adc_lrc_o), 0);
        check("R1 oe in reset", int'(bclk_oe | adc_lrc_oe | dac_lrc_oe), 0);
        rst_n = 1'b1;
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int per;
        int codes [13] = '{1, 11, 9, 10, 2, 3, 4, 5, 6, 7, 8, 12, 0};
        @(negedge clk);
        do_reset();
        run(600);

        foreach (codes[k]) begin
            rate_sel = 4'(codes[k]);
            run(3500);
            if (codes[k] == 1) begin
                meas(1, per); check("R3 code1 record frame period", per, 1536);
                meas(2, per); check("R3 code1 playback frame period", per, 256);
            end
            if (codes[k] == 11) begin
                meas(2, per); check("R3 code11 playback frame period", per, 768);
                meas(0, per); check("R2 code11 bclk period", per, 4);
            end
        end

        // Gating checks, per path and shared.
        adc_en = 1'b0; run(300);
        check("R9 adc gated off", int'(adc_lrc_oe), 0);
        check("R9 dac still on", int'(dac_lrc_oe), 1);
        lrc_share = 1'b1; run(300);
        check("R10 shared keeps adc on", int'(adc_lrc_oe), 1);
        dac_en = 1'b0; run(300);
        check("R10 shared both off", int'(adc_lrc_oe | dac_lrc_oe), 0);
        lrc_share = 1'b0; adc_en = 1'b1; run(300);
        check("R9 dac gated alone", int'(dac_lrc_oe), 0);
        dac_en = 1'b1;
        master_en = 1'b0; run(300);
        check("R8 slave no drive", int'(bclk_oe | adc_lrc_oe | dac_lrc_oe | bclk_o), 0);
        master_en = 1'b1; run(300);

        // Rate change in the middle of a long frame waits for the boundary.
        rate_sel = 4'd3; do_reset();
        run(700);
        rate_sel = 4'd5;
        meas(0, per); check("R7 old bclk period kept", per, 24);
        run(2000);
        meas(0, per); check("R7 new bclk period", per, 2);

        // Halved master clock.
        mclk_halve = 1'b1; do_reset();
        meas(0, per); check("R6 halved bclk period", per, 4);
        run(1500);
        rate_sel = 4'd1; run(7000);
        meas(2, per); check("R6 halved playback frame", per, 512);
        mclk_halve = 1'b0; rate_sel = 4'd0;
        run(2000);
        do_reset();
        run(500);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule